// File: doc/BRIEF.md
# Cache Remap Tag Buffer

This block sits between the cores and a DRAM cache controller. Each core keeps a 3-bit cache location for every page in its translation entry. That location can go stale when a page is moved into the DRAM cache or moved within it. Instead of messaging every core when this happens, the core that moves the page writes the new location into this small associative buffer. Every request bound for the DRAM cache or for main memory passes through the buffer. If the page tag of a request matches a buffered record, the buffered location replaces the location the request carries. If it does not match, the request's own bits go through unchanged. Either way the result reaches the controller one cycle later.

A location has two parts: a residency bit, where 1 means the page is held in the DRAM cache, and a 2-bit way field that gives the page's slot among the pages sharing its hash index. Records fill the buffer in arrival order. A record for a tag that is already held is updated in place. When the last free slot is taken, the buffer asks all cores to refresh their translation tables and stops taking records. After the acknowledge arrives, the buffer empties itself in one step and starts again.

The default size is 1024 records, each holding a 36-bit tag, 3 location bits and a valid bit. That comes to about 5 KB.

Top module: `remap_tag_buf`

## Requirements
- R1: After a synchronous reset with rst_n low, out_valid and out_hit are 0, refresh_req is 0, ins_ready is 1 and the buffer holds no records.
- R2: While the buffer holds no records, every lookup returns out_hit = 0, and out_resident and out_way are equal to the request's own req_resident and req_way.
- R3: A lookup whose tag matches a held record returns out_hit = 1, with out_resident (1 = page held in the DRAM cache) and out_way (2-bit slot within the hash index) taken from that record.
- R4: A lookup whose tag matches no held record returns out_hit = 0 and passes req_resident and req_way through unchanged, even when other records are held.
- R5: The lookup result is registered. out_valid, out_tag, out_hit, out_resident and out_way show the request presented at one rising edge from that edge until the next one, and out_valid is 0 for a cycle in which req_valid was 0.
- R6: An insert is accepted at a rising edge where ins_valid and ins_ready are both 1. A new tag takes a free record, and lookups at later edges see it.
- R7: An accepted insert of a tag that is already held replaces that record's location and does not use a free record. Filling the buffer still takes ENTRIES distinct tags.
- R8: Once ENTRIES distinct tags are held, refresh_req is 1 and ins_ready is 0. Both stay that way until refresh_ack is sampled high.
- R9: An insert offered while ins_ready is 0 has no effect. A later lookup of that tag misses.
- R10: While refresh_req is 1, lookups still return results from the records currently held.
- R11: When refresh_ack is 1 at a rising edge while refresh_req is 1, then from that edge on all records are empty, refresh_req is 0 and ins_ready is 1.
- R12: A lookup presented at the same edge as an accepted insert, or as an acknowledged clear, is judged against the contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented for lookup |
| req_tag | input | TAG_W | Page tag of the request |
| req_resident | input | 1 | Residency bit carried from the core's translation entry |
| req_way | input | 2 | Way bits carried from the core's translation entry |
| out_valid | output | 1 | Registered request toward the cache controller |
| out_tag | output | TAG_W | Registered page tag |
| out_resident | output | 1 | Residency bit after override |
| out_way | output | 2 | Way bits after override |
| out_hit | output | 1 | The request matched a buffered record |
| ins_valid | input | 1 | A core offers a new location record |
| ins_tag | input | TAG_W | Page tag of the offered record |
| ins_resident | input | 1 | New residency bit |
| ins_way | input | 2 | New way bits |
| ins_ready | output | 1 | The buffer can accept a record |
| refresh_req | output | 1 | All cores must refresh their translation tables |
| refresh_ack | input | 1 | The refresh has completed |

## Verification
Lookup can fall in the same cycle as either of the two operations that change the buffer: inserting a record and the clear that follows an acknowledge. The bench provokes both. In one case it presents a lookup and an insert of the same previously unseen tag at a single edge. In the other it raises refresh_ack together with a lookup of a held tag. In the first case the registered result must be a miss that passes the request's bits through, and a lookup one cycle later must hit. In the second case the result must still carry the held record, while refresh_req falls and ins_ready rises at that same edge.

// File: rtl/rtb_pkg.sv
// Shared types for the remap tag buffer.
// Assumes a page location is always 3 bits: a residency bit and a 2-bit way.
package rtb_pkg;
    localparam int LOC_W = 3;

    typedef struct packed {
        logic       resident;
        logic [1:0] way;
    } loc_t;
endpackage

// File: rtl/rtb_cam_array.sv
// Associative record store with two match ports: one for lookup and one
// for the insert path, which checks whether a tag is already held.
// Assumes the tags held are unique; the insert path guarantees this.
// Holds one write port, plus a bulk clear that drops every valid bit.
module rtb_cam_array
    import rtb_pkg::*;
#(
    parameter int TAG_W   = 36,
    parameter int ENTRIES = 1024,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output loc_t             look_loc,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             probe_hit,
    output logic [IDX_W-1:0] probe_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  loc_t             wr_loc,
    input  logic             clear
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    loc_t               loc_q [ENTRIES];
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] probe_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Per-record storage: clear drops validity, a write fills the record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                loc_q[i]   <= '0;
            end else if (clear) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                tag_q[i]   <= wr_tag;
                loc_q[i]   <= wr_loc;
            end
        end

        assign look_match[i]  = valid_q[i] && (tag_q[i] == look_tag);
        assign probe_match[i] = valid_q[i] && (tag_q[i] == probe_tag);
    end

    // OR-reduce the location of the single matching record.
    always_comb begin
        look_loc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) look_loc = look_loc | loc_q[i];
        end
    end

    // Encode the index of the record that matches the insert tag.
    always_comb begin
        probe_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (probe_match[i]) probe_idx = probe_idx | IDX_W'(i);
        end
    end

    assign look_hit  = |look_match;
    assign probe_hit = |probe_match;

    // R7
    uniq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match) && $onehot0(probe_match));

    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0));
endmodule

// File: rtl/rtb_fill_ctrl.sv
// Occupancy counter and the refresh handshake.
// Assumes alloc is only raised while the buffer is not full.
// The buffer is full when the count equals ENTRIES. An acknowledge while
// full resets the count, and the clear happens at that same edge.
module rtb_fill_ctrl #(
    parameter int ENTRIES = 1024,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             ack,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             clear
);
    logic [CNT_W-1:0] count_q;

    assign full  = (count_q == CNT_W'(ENTRIES));
    assign clear = full && ack;
    assign count = count_q;

    // Count allocated records; return to zero on an acknowledged refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (clear)  count_q <= '0;
        else if (alloc)  count_q <= count_q + 1'b1;
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(ENTRIES));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ack) |=> full);

    // R11
    clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ack) |=> (!full && count_q == '0));
endmodule

// File: rtl/rtb_lookup_stage.sv
// Override mux and the registered output toward the cache controller.
// Assumes hit and buf_loc come combinationally from the current contents.
module rtb_lookup_stage
    import rtb_pkg::*;
#(
    parameter int TAG_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  loc_t             req_loc,
    input  logic             hit,
    input  loc_t             buf_loc,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output loc_t             out_loc,
    output logic             out_hit
);
    // Register the request, with the location chosen by the match result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_loc   <= '0;
            out_hit   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_tag   <= req_tag;
            out_loc   <= hit ? buf_loc : req_loc;
            out_hit   <= req_valid && hit;
        end
    end

    // R5
    out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid && out_tag == $past(req_tag)));

    // R3
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit) |=> out_hit);
endmodule

// File: rtl/remap_tag_buf.sv
// Remap tag buffer top. Requests are looked up combinationally and then
// registered. Inserts either update a record in place or allocate the next
// free slot. When the buffer is full it raises refresh_req, blocks inserts,
// and clears every record at the edge where refresh_ack is seen.
// Assumes ENTRIES >= 2. Default sizing: 1024 x (36 + 3 + 1) bits = 5 KB.
module remap_tag_buf
    import rtb_pkg::*;
#(
    parameter int TAG_W   = 36,
    parameter int ENTRIES = 1024,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_resident,
    input  logic [1:0]       req_way,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_resident,
    output logic [1:0]       out_way,
    output logic             out_hit,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             ins_resident,
    input  logic [1:0]       ins_way,
    output logic             ins_ready,
    output logic             refresh_req,
    input  logic             refresh_ack
);
    logic             look_hit;
    loc_t             look_loc;
    logic             probe_hit;
    logic [IDX_W-1:0] probe_idx;
    logic             ins_fire;
    logic             alloc;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             clear;
    loc_t             req_loc;
    loc_t             ins_loc;
    loc_t             out_loc;

    assign req_loc      = '{resident: req_resident, way: req_way};
    assign ins_loc      = '{resident: ins_resident, way: ins_way};
    assign ins_ready    = !full;
    assign refresh_req  = full;
    assign ins_fire     = ins_valid && ins_ready;
    assign alloc        = ins_fire && !probe_hit;
    assign wr_idx       = probe_hit ? probe_idx : IDX_W'(count);
    assign out_resident = out_loc.resident;
    assign out_way      = out_loc.way;

    rtb_cam_array #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) cam_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_tag  (req_tag),
        .look_hit  (look_hit),
        .look_loc  (look_loc),
        .probe_tag (ins_tag),
        .probe_hit (probe_hit),
        .probe_idx (probe_idx),
        .wr_en     (ins_fire),
        .wr_idx    (wr_idx),
        .wr_tag    (ins_tag),
        .wr_loc    (ins_loc),
        .clear     (clear)
    );

    rtb_fill_ctrl #(.ENTRIES(ENTRIES)) fill_i (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .ack   (refresh_ack),
        .count (count),
        .full  (full),
        .clear (clear)
    );

    rtb_lookup_stage #(.TAG_W(TAG_W)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_tag   (req_tag),
        .req_loc   (req_loc),
        .hit       (look_hit),
        .buf_loc   (look_loc),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_loc   (out_loc),
        .out_hit   (out_hit)
    );

    // R2
    empty_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && req_valid) |=> (!out_hit && out_loc == $past(req_loc)));

    // R9
    blocked_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !refresh_ack) |=> $stable(count));

    // R7
    update_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && probe_hit) |=> $stable(count));
endmodule

// File: tb/remap_tag_buf_tb_top.sv
// Bench for remap_tag_buf in a small configuration (6-bit tags, 4 records).
// It sweeps every tag against a model of the requirements.
module remap_tag_buf_tb_top;
    localparam int TW = 6;
    localparam int NE = 4;
    localparam int NT = 1 << TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic          req_resident = 1'b0;
    logic [1:0]    req_way = '0;
    logic          out_valid;
    logic [TW-1:0] out_tag;
    logic          out_resident;
    logic [1:0]    out_way;
    logic          out_hit;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_tag = '0;
    logic          ins_resident = 1'b0;
    logic [1:0]    ins_way = '0;
    logic          ins_ready;
    logic          refresh_req;
    logic          refresh_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [TW-1:0] mtag [NE];
    logic [2:0]    mloc [NE];
    int            mcnt = 0;

    always #4 clk = ~clk;

    remap_tag_buf #(.TAG_W(TW), .ENTRIES(NE)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int find(input logic [TW-1:0] t);
        for (int i = 0; i < mcnt; i++) if (mtag[i] == t) return i;
        return -1;
    endfunction

    // Expected registered result {valid, tag, hit, resident, way}.
    function automatic logic [31:0] expect_out(input logic [TW-1:0] t, input logic [2:0] rl);
        int k = find(t);
        if (k >= 0) return {1'b1, t, 1'b1, mloc[k]};
        return {1'b1, t, 1'b0, rl};
    endfunction

    function automatic logic [31:0] got_out();
        return {out_valid, out_tag, out_hit, out_resident, out_way};
    endfunction

    task automatic lookup(input logic [TW-1:0] t, input logic [2:0] rl, input string req);
        logic [31:0] e;
        e = expect_out(t, rl);
        req_valid = 1'b1; req_tag = t; {req_resident, req_way} = rl;
        @(posedge clk); @(negedge clk);
        chk(req, got_out(), e);
        req_valid = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int t = 0; t < NT; t++) lookup(TW'(t), 3'(t) ^ 3'b101, req);
    endtask

    function automatic void model_insert(input logic [TW-1:0] t, input logic [2:0] l);
        int k = find(t);
        if (k >= 0) mloc[k] = l;
        else if (mcnt < NE) begin mtag[mcnt] = t; mloc[mcnt] = l; mcnt++; end
    endfunction

    task automatic insert(input logic [TW-1:0] t, input logic [2:0] l);
        ins_valid = 1'b1; ins_tag = t; {ins_resident, ins_way} = l;
        @(posedge clk);
        model_insert(t, l);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_hit", out_hit, 0);
        chk("R1 refresh_req", refresh_req, 0);
        chk("R1 ins_ready", ins_ready, 1);
        // R2 and R5: the empty buffer passes the request's bits through
        sweep("R2/R5 empty");
        @(negedge clk);
        chk("R5 idle out_valid", out_valid, 0);

        // R6, R3, R4: two records, then a full sweep
        insert(6'd5, 3'b110);
        insert(6'd17, 3'b011);
        sweep("R3/R4/R6 two records");

        // R7: update in place, no capacity consumed
        insert(6'd5, 3'b100);
        lookup(6'd5, 3'b011, "R7 updated loc");
        chk("R7 no refresh", refresh_req, 0);

        // R12: lookup and insert of a new tag at the same edge
        req_valid = 1'b1; req_tag = 6'd40; {req_resident, req_way} = 3'b001;
        ins_valid = 1'b1; ins_tag = 6'd40; {ins_resident, ins_way} = 3'b111;
        @(posedge clk); @(negedge clk);
        chk("R12 same-edge insert", got_out(), {1'b1, 6'd40, 1'b0, 3'b001});
        model_insert(6'd40, 3'b111);
        req_valid = 1'b0; ins_valid = 1'b0;
        lookup(6'd40, 3'b000, "R6 visible next cycle");

        // R8: the fourth distinct tag fills the buffer
        chk("R7 ready with 3 records", ins_ready, 1);
        insert(6'd63, 3'b010);
        chk("R8 refresh_req", refresh_req, 1);
        chk("R8 ins_ready", ins_ready, 0);

        // R9: an insert offered while full is ignored
        ins_valid = 1'b1; ins_tag = 6'd9; {ins_resident, ins_way} = 3'b101;
        repeat (3) @(negedge clk);
        ins_valid = 1'b0;
        lookup(6'd9, 3'b010, "R9 blocked insert misses");
        // R10: lookups stay live while the refresh is pending
        sweep("R10 pending refresh");
        chk("R8 still pending", refresh_req, 1);

        // R11 and R12: acknowledge together with a lookup of a held tag
        refresh_ack = 1'b1;
        req_valid = 1'b1; req_tag = 6'd63; {req_resident, req_way} = 3'b000;
        @(posedge clk); @(negedge clk);
        chk("R12 lookup at clear edge", got_out(), {1'b1, 6'd63, 1'b1, 3'b010});
        chk("R11 refresh_req low", refresh_req, 0);
        chk("R11 ins_ready high", ins_ready, 1);
        refresh_ack = 1'b0; req_valid = 1'b0;
        mcnt = 0;
        sweep("R11 cleared");

        // Second round with arithmetic tags and locations
        for (int i = 0; i < NE; i++) begin
            chk("R8 not full yet", refresh_req, 0);
            insert(TW'(i * 11 + 3), 3'(i * 3 + 1));
        end
        chk("R8 full again", refresh_req, 1);
        sweep("R3/R10 second round");
        refresh_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        refresh_ack = 1'b0;
        mcnt = 0;
        chk("R11 second clear", ins_ready, 1);
        sweep("R11 second clear empty");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule